// File: doc/BRIEF.md
# Receiver Polling Mode Sequencer

This block duty-cycles a low-power radio receiver so that it listens only briefly and sleeps most of the time. It moves through four phases. In sleep the signal path is off. In start-up the signal path is powered and given time to settle. In bit-check an external timing checker judges the incoming stream. In receive the signal path stays on and data passes through to the host. One down-counter, reloaded on every phase change, sets how long each timed phase lasts.

The sleep length is the programmed 5-bit word times an extension factor times a fixed clock unit. The start-up length and the bit-check timeout both depend on a 2-bit baud-range select: a faster range gives a shorter wait. The bit checker reports its verdict as single-cycle pass or fail pulses. A host, or the data line, ends a reception with a single-cycle OFF pulse.

Top module: `rx_poll_sequencer`

## Requirements
- R1: While reset is low, and on the first cycle after it rises, the block is in sleep with all four outputs low. Reset loads the sleep timer from the current configuration.
- R2: The outputs decode the phase. `ic_active_o` and `sig_en_o` are low in sleep and high in every other phase. `chk_en_o` is high only in bit-check. `data_pass_o` is high only in receive.
- R3: Sleep lasts W × X × CLK_UNIT clock cycles. W is `sleep_word_i`, with 0 treated as 1. X is EXT_LONG when `ext_sel_i` is 2'b01 and 1 for any other code. Both inputs are sampled when sleep is entered.
- R4: Start-up lasts STARTUP_MIN × 2^(3 − `baud_sel_i`) cycles, with the baud select sampled when start-up is entered. Bit-check follows.
- R5: A pass pulse during bit-check, with no fail or OFF in the same cycle, moves the block to receive on the next cycle. This holds even on the last cycle of the timeout window.
- R6: A fail pulse during bit-check returns the block to sleep on the next cycle. Fail wins over a pass in the same cycle.
- R7: If no verdict arrives within 16 × BITPER_MIN × 2^(3 − `baud_sel_i`) cycles of bit-check, the block returns to sleep. The baud select is sampled on entry to bit-check.
- R8: Receive holds for as long as no OFF pulse arrives, whatever the state of pass and fail.
- R9: An OFF pulse in start-up, bit-check or receive moves the block to sleep on the next cycle. OFF takes priority over every other event.
- R10: Pass, fail and OFF have no effect in sleep. Pass and fail have no effect in start-up and receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Basic clock; all timing counts its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_word_i | input | 5 | Sleep multiplier word W |
| ext_sel_i | input | 2 | Extension-factor select (2'b01 = long) |
| baud_sel_i | input | 2 | Baud range, 0 slowest to 3 fastest |
| chk_pass_i | input | 1 | Single-cycle bit-check pass pulse |
| chk_fail_i | input | 1 | Single-cycle bit-check fail pulse |
| off_cmd_i | input | 1 | Single-cycle OFF command |
| sig_en_o | output | 1 | Signal-path enable |
| ic_active_o | output | 1 | High outside sleep |
| chk_en_o | output | 1 | Bit-checker enable |
| data_pass_o | output | 1 | Data pass-through enable |

## Verification
The risky collisions happen in bit-check. There, an OFF pulse, a fail pulse, a pass pulse and the expiry of the verdict timeout can all land on the same clock edge. Directed cases place OFF together with pass, pass together with fail, and pass on the very last cycle of the timeout window. A long random run then scatters all three pulses over every phase and every configuration code. A cycle-level reference model in the bench applies the priority order OFF, fail, pass, timeout and gives the expected phase for every cycle, which is compared against the four outputs.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
    typedef enum logic [1:0] {
        PH_SLEEP   = 2'd0,
        PH_STARTUP = 2'd1,
        PH_BITCHK  = 2'd2,
        PH_RECV    = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   sig_en;
        logic   active;
        logic   chk_en;
        logic   data_pass;
    } seq_st_t;
endpackage

// File: rtl/rxp_sleep_len.sv
module rxp_sleep_len #(
    parameter int WORD_W   = 5,
    parameter int CLK_UNIT = 1024,
    parameter int EXT_LONG = 8,
    parameter int CNT_W    = 18
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [1:0]        ext_sel_i,
    output logic [CNT_W-1:0]  len_o
);
    logic [CNT_W-1:0] w_eff;
    logic [CNT_W-1:0] x_eff;

    always_comb begin
        // a zero word would mean a zero-length sleep; use one instead
        w_eff = (word_i == '0) ? CNT_W'(1) : CNT_W'(word_i);
        // only code 01 selects the long factor; the remaining codes give 1
        x_eff = (ext_sel_i == 2'b01) ? CNT_W'(EXT_LONG) : CNT_W'(1);
        len_o = w_eff * x_eff * CNT_W'(CLK_UNIT);
    end
endmodule

// File: rtl/rxp_baud_len.sv
module rxp_baud_len #(
    parameter int BASE  = 512,
    parameter int CNT_W = 18
) (
    input  logic [1:0]       baud_i,
    output logic [CNT_W-1:0] len_o
);
    // range 3 is the fastest and gives BASE; each slower range doubles it
    always_comb begin
        len_o = CNT_W'(BASE) << (2'd3 - baud_i);
    end
endmodule

// File: rtl/rxp_down_timer.sv
module rxp_down_timer #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q == '0)
            cnt_d = '0;
        else
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i))); // R3

    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/rx_poll_sequencer.sv
module rx_poll_sequencer
    import rxp_pkg::*;
#(
    parameter int WORD_W      = 5,
    parameter int CLK_UNIT    = 1024,
    parameter int EXT_LONG    = 8,
    parameter int STARTUP_MIN = 512,
    parameter int BITPER_MIN  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] sleep_word_i,
    input  logic [1:0]        ext_sel_i,
    input  logic [1:0]        baud_sel_i,
    input  logic              chk_pass_i,
    input  logic              chk_fail_i,
    input  logic              off_cmd_i,
    output logic              sig_en_o,
    output logic              ic_active_o,
    output logic              chk_en_o,
    output logic              data_pass_o
);
    localparam int SLEEP_MAX = ((1 << WORD_W) - 1) * EXT_LONG * CLK_UNIT;
    localparam int ST_MAX    = STARTUP_MIN * 8;
    localparam int WD_BASE   = 16 * BITPER_MIN;
    localparam int WD_MAX    = WD_BASE * 8;
    localparam int MAX_A     = (SLEEP_MAX > ST_MAX) ? SLEEP_MAX : ST_MAX;
    localparam int MAX_ALL   = (MAX_A > WD_MAX) ? MAX_A : WD_MAX;
    localparam int CNT_W     = $clog2(MAX_ALL + 1);

    seq_st_t          st_d, st_q;
    logic [CNT_W-1:0] sleep_len, start_len, wd_len;
    logic [CNT_W-1:0] ld_val;
    logic             ld;
    logic             t_zero;

    rxp_sleep_len #(
        .WORD_W(WORD_W), .CLK_UNIT(CLK_UNIT), .EXT_LONG(EXT_LONG), .CNT_W(CNT_W)
    ) u_sleep_len (
        .word_i(sleep_word_i), .ext_sel_i(ext_sel_i), .len_o(sleep_len)
    );

    // one baud-scaled length per timed phase after sleep
    for (genvar g = 0; g < 2; g++) begin : g_baud
        logic [CNT_W-1:0] len;
        rxp_baud_len #(
            .BASE((g == 0) ? STARTUP_MIN : WD_BASE), .CNT_W(CNT_W)
        ) u_len (
            .baud_i(baud_sel_i), .len_o(len)
        );
    end
    assign start_len = g_baud[0].len;
    assign wd_len    = g_baud[1].len;

    rxp_down_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(ld), .load_val_i(ld_val), .zero_o(t_zero)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_SLEEP: begin
                if (t_zero) st_d.phase = PH_STARTUP;
            end
            PH_STARTUP: begin
                if (off_cmd_i)   st_d.phase = PH_SLEEP;
                else if (t_zero) st_d.phase = PH_BITCHK;
            end
            PH_BITCHK: begin
                if (off_cmd_i)       st_d.phase = PH_SLEEP;
                else if (chk_fail_i) st_d.phase = PH_SLEEP;
                else if (chk_pass_i) st_d.phase = PH_RECV;
                else if (t_zero)     st_d.phase = PH_SLEEP;
            end
            PH_RECV: begin
                if (off_cmd_i) st_d.phase = PH_SLEEP;
            end
            default: st_d.phase = PH_SLEEP;
        endcase

        if (!rst_n) st_d.phase = PH_SLEEP;

        // reload the timer on every phase change and throughout reset
        ld = !rst_n || (st_d.phase != st_q.phase);
        unique case (st_d.phase)
            PH_STARTUP: ld_val = start_len - CNT_W'(1);
            PH_BITCHK:  ld_val = wd_len - CNT_W'(1);
            default:    ld_val = sleep_len - CNT_W'(1);
        endcase

        st_d.sig_en    = (st_d.phase != PH_SLEEP);
        st_d.active    = (st_d.phase != PH_SLEEP);
        st_d.chk_en    = (st_d.phase == PH_BITCHK);
        st_d.data_pass = (st_d.phase == PH_RECV);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sig_en_o    = st_q.sig_en;
    assign ic_active_o = st_q.active;
    assign chk_en_o    = st_q.chk_en;
    assign data_pass_o = st_q.data_pass;

    AST_RECV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_pass_o && !off_cmd_i) |=> data_pass_o); // R8

    AST_OFF_TO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_active_o && off_cmd_i) |=> !ic_active_o); // R9

    AST_PASS_TO_RECV: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en_o && chk_pass_i && !chk_fail_i && !off_cmd_i) |=> data_pass_o); // R5

    AST_FAIL_TO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en_o && chk_fail_i) |=> !ic_active_o); // R6

    AST_SLEEP_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ic_active_o && !t_zero) |=> !ic_active_o); // R10

    AST_STARTUP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_STARTUP && !t_zero && !off_cmd_i) |=> (st_q.phase == PH_STARTUP)); // R4

    AST_ONE_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chk_en_o, data_pass_o, !ic_active_o})); // R2
endmodule

// File: tb/sim_rx_poll_sequencer.sv
module sim_rx_poll_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int U_UNIT = 4;
    localparam int U_EXT  = 8;
    localparam int U_ST   = 4;
    localparam int U_BIT  = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] sleep_word = 5'd2;
    logic [1:0] ext_sel = 2'd0;
    logic [1:0] baud_sel = 2'd3;
    logic       pass_p = 1'b0, fail_p = 1'b0, off_p = 1'b0;
    logic       sig_en, active, chk_en, dpass;

    int errors = 0;
    int checks = 0;
    int m_ph   = 0;   // 0 sleep, 1 start-up, 2 bit-check, 3 receive
    int m_cnt  = 0;

    rx_poll_sequencer #(
        .WORD_W(5), .CLK_UNIT(U_UNIT), .EXT_LONG(U_EXT),
        .STARTUP_MIN(U_ST), .BITPER_MIN(U_BIT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .sleep_word_i(sleep_word), .ext_sel_i(ext_sel),
        .baud_sel_i(baud_sel), .chk_pass_i(pass_p), .chk_fail_i(fail_p),
        .off_cmd_i(off_p), .sig_en_o(sig_en), .ic_active_o(active),
        .chk_en_o(chk_en), .data_pass_o(dpass)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int f_sleep(input logic [4:0] w, input logic [1:0] e);
        int wv = (w == 0) ? 1 : int'(w);
        int xv = (e == 2'b01) ? U_EXT : 1;
        return wv * xv * U_UNIT;
    endfunction

    function automatic int f_start(input logic [1:0] b);
        return U_ST << (3 - int'(b));
    endfunction

    function automatic int f_wd(input logic [1:0] b);
        return (16 * U_BIT) << (3 - int'(b));
    endfunction

    task automatic enter(input int ph);
        m_ph = ph;
        case (ph)
            0: m_cnt = f_sleep(sleep_word, ext_sel);
            1: m_cnt = f_start(baud_sel);
            2: m_cnt = f_wd(baud_sel);
            default: m_cnt = 0;
        endcase
    endtask

    task automatic model_tick();
        if (!rst_n) begin
            enter(0);
            return;
        end
        case (m_ph)
            0: if (m_cnt == 1) enter(1); else m_cnt--;
            1: if (off_p) enter(0); else if (m_cnt == 1) enter(2); else m_cnt--;
            2: begin
                if (off_p)           enter(0);
                else if (fail_p)     enter(0);
                else if (pass_p)     enter(3);
                else if (m_cnt == 1) enter(0);
                else m_cnt--;
            end
            default: if (off_p) enter(0);
        endcase
    endtask

    task automatic step(input string req);
        logic [3:0] exp_v, act_v;
        @(posedge clk);
        model_tick();
        @(negedge clk);
        exp_v = {m_ph != 0, m_ph != 0, m_ph == 2, m_ph == 3};
        act_v = {sig_en, active, chk_en, dpass};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: outputs {sig,act,chk,pass} got %b expected %b (phase %0d)",
                     req, act_v, exp_v, m_ph);
        end
        pass_p = 1'b0;
        fail_p = 1'b0;
        off_p  = 1'b0;
    endtask

    task automatic wait_phase(input int ph, input string req);
        for (int i = 0; i < 4000 && m_ph != ph; i++) step(req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        // R1: reset state
        for (int i = 0; i < 3; i++) step("R1");
        rst_n = 1'b1;
        step("R1");

        // R3/R4/R2: nominal sleep (2*1*4) and start-up at range 3
        wait_phase(1, "R3");
        wait_phase(2, "R4");
        step("R2");
        // R5: pass moves to receive
        pass_p = 1'b1; step("R5");
        // R8: receive held despite pass/fail noise
        for (int i = 0; i < 20; i++) begin
            fail_p = (i % 3 == 0); pass_p = (i % 5 == 0);
            step("R8");
        end
        // R9: OFF ends receive
        off_p = 1'b1; step("R9");

        // R3: word 0 treated as 1, long factor; R4 slowest start-up
        sleep_word = 5'd0; ext_sel = 2'b01; baud_sel = 2'd0;
        wait_phase(1, "R3");
        sleep_word = 5'd7; ext_sel = 2'b10;
        wait_phase(2, "R4");
        // R6: pass and fail together -> sleep
        pass_p = 1'b1; fail_p = 1'b1; step("R6");
        step("R6");

        // R7: timeout at range 2 with no verdict
        baud_sel = 2'd2;
        wait_phase(2, "R7");
        wait_phase(0, "R7");

        // R10: pulses in sleep and start-up are ignored
        for (int i = 0; i < 6; i++) begin
            pass_p = 1'b1; fail_p = (i[0]); off_p = (i == 2);
            step("R10");
        end
        wait_phase(1, "R10");
        pass_p = 1'b1; step("R10");
        fail_p = 1'b1; step("R10");
        // R9: OFF during start-up
        off_p = 1'b1; step("R9");

        // R5: pass on the last cycle of the window; baud 3
        baud_sel = 2'd3;
        wait_phase(2, "R5");
        while (m_cnt > 1) step("R7");
        pass_p = 1'b1; step("R5");
        // R9: OFF together with pass in bit-check
        off_p = 1'b1; step("R9");
        wait_phase(2, "R9");
        off_p = 1'b1; pass_p = 1'b1; step("R9");

        // random phase
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 49) == 0) begin
                sleep_word = 5'($urandom_range(0, 3));
                ext_sel    = 2'($urandom_range(0, 3));
                baud_sel   = 2'($urandom_range(0, 3));
            end
            pass_p = ($urandom_range(0, 19) == 0);
            fail_p = ($urandom_range(0, 39) == 0);
            off_p  = ($urandom_range(0, 149) == 0);
            step("R2");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule